// File: doc/BRIEF.md
# Boot handshake frame generator

This block opens a lockout-chip style boot handshake over a single open-drain data line that an external, much slower handshake clock times. After a start pulse it sends three frames back to back:
- a 4-bit identifier;
- a 6-nibble seed frame;
- a 16-nibble checksum frame, preceded by one zero bit.

Before each data frame is shifted out, a 16-nibble working buffer is scrambled in place. The scrambling applies a chaining encode round a fixed number of times.

The external clock is resynchronised into the system clock domain. A bit is driven on a falling edge of the handshake clock by pulling the line low when the bit is 0, and the line is let go on the following rising edge. The seed, checksum and both flags are captured when the start pulse is accepted. A one-cycle done pulse marks the release of the final checksum bit.

Top module: `hs_frame_gen`

## Requirements
- R1: After reset, and whenever the block is idle, `line_pull` is 0 and `done` is 0. An active-low reset in the middle of a frame releases the line and returns the block to idle, and a new start then produces a complete, correct frame.
- R2: `line_pull` rises only after a falling edge of `hs_clk` whose bit is 0. It returns to 0 after the following rising edge of `hs_clk`.
- R3: The stream is exactly 93 bits long: 4 identifier bits, 24 seed bits, one gap bit, then 64 checksum bits. Every nibble is sent most significant bit first.
- R4: The identifier bits, in send order, are `disk_mode`, `region_pal`, 0, 1.
- R5: The seed frame loads buffer nibbles 10..15 with 0xB, 0x5, seed[7:4], seed[3:0], seed[7:4], seed[3:0]. It then applies two encode rounds based at 10 and sends nibbles 10 to 15 in ascending order.
- R6: An encode round based at p keeps nibble p as the running value d. For each higher index i up to 15 it sets d = (d + 1 + buf[i]) mod 16 and writes d into buf[i].
- R7: The checksum frame loads nibbles 0..3 with zero and nibbles 4..15 with `csum` from bit 47 downward, four bits per nibble (upper nibble of each byte first). It then applies four encode rounds based at 0 and sends nibbles 0 to 15 in ascending order.
- R8: The gap bit between the seed frame and the checksum frame is 0.
- R9: `done` is high for exactly one system clock cycle per frame, after the rising edge that ends the last checksum bit.
- R10: A start pulse while a frame is in progress is ignored. Input changes after the accepted start have no effect on the stream.
- R11: `hs_clk` edges while idle leave `line_pull` at 0 and produce no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a handshake when idle |
| seed | input | 8 | Seed byte, captured at start |
| csum | input | 48 | Six checksum bytes, first byte in bits 47:40 |
| region_pal | input | 1 | 1 selects the 50 Hz region |
| disk_mode | input | 1 | Disk-mode flag |
| hs_clk | input | 1 | External handshake clock, asynchronous |
| line_pull | output | 1 | 1 drives the open-drain data line low |
| done | output | 1 | One-cycle pulse when the frame is complete |

## Verification
The frame is run with four operand sets:
- **Default operands** (seed 0x3F, checksum A5 36 C0 F1 D8 59): the reference case.
- **All zeros with both flags set**: shows every identifier bit is placed correctly, and that the encoding still produces non-zero nibbles from the +1 term alone.
- **All ones with only disk mode set**: exposes mod-16 wrap mistakes and swapped identifier flags.
- **Walking checksum pattern**: has distinct nibbles, so any error in byte order, nibble order or round count changes the received stream.

Directed runs cover a start pulse with altered inputs mid-frame, a reset while the line is pulled low, and clock edges while idle.

// File: rtl/hs_frame_gen.sv
module hs_frame_gen #(
  parameter int SEED_ROUNDS = 2,
  parameter int CSUM_ROUNDS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  seed,
  input  logic [47:0] csum,
  input  logic        region_pal,
  input  logic        disk_mode,
  input  logic        hs_clk,
  output logic        line_pull,
  output logic        done
);
  localparam logic [2:0] PH_IDLE = 3'd0, PH_ID = 3'd1, PH_SEED = 3'd2,
                         PH_GAP = 3'd3, PH_CSUM = 3'd4;
  localparam logic [3:0] SEED_BASE = 4'd10;

  logic [2:0]  phase;
  logic [5:0]  bitcnt;
  logic [2:0]  sy;
  logic        armed;
  logic [2:0]  enc_left;
  logic [3:0]  enc_base;
  logic [1:0]  id_q;
  logic [47:0] csum_q;
  logic [3:0]  buf_q   [16];
  logic [3:0]  buf_enc [16];
  logic [3:0]  d;
  logic        cur, last, fall, rise;
  logic [3:0]  seed_idx;

  assign fall = sy[2] & ~sy[1];
  assign rise = ~sy[2] & sy[1];
  assign seed_idx = SEED_BASE + {1'b0, bitcnt[4:2]};

  always_comb begin
    buf_enc = buf_q;
    d = buf_q[enc_base];
    for (int i = 1; i < 16; i++) begin
      if (i > int'(enc_base)) begin
        d = d + 4'd1 + buf_q[i];
        buf_enc[i] = d;
      end
    end
  end

  always_comb begin
    case (phase)
      PH_ID:   cur = {id_q, 2'b01}[~bitcnt[1:0]];
      PH_SEED: cur = buf_q[seed_idx][~bitcnt[1:0]];
      PH_CSUM: cur = buf_q[bitcnt[5:2]][~bitcnt[1:0]];
      default: cur = 1'b0;
    endcase
  end

  assign last = (phase == PH_ID   && bitcnt == 6'd3)  ||
                (phase == PH_SEED && bitcnt == 6'd23) ||
                (phase == PH_GAP)                     ||
                (phase == PH_CSUM && bitcnt == 6'd63);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      bitcnt <= '0;
      sy <= 3'b111;
      armed <= 1'b0;
      enc_left <= '0;
      enc_base <= '0;
      id_q <= '0;
      csum_q <= '0;
      line_pull <= 1'b0;
      done <= 1'b0;
      for (int i = 0; i < 16; i++) buf_q[i] <= '0;
    end else begin
      sy <= {sy[1:0], hs_clk};
      done <= 1'b0;
      if (enc_left != 3'd0) begin
        buf_q <= buf_enc;
        enc_left <= enc_left - 3'd1;
      end
      if (phase == PH_IDLE) begin
        if (start) begin
          phase <= PH_ID;
          bitcnt <= '0;
          armed <= 1'b0;
          id_q <= {disk_mode, region_pal};
          csum_q <= csum;
          buf_q[10] <= 4'hB;
          buf_q[11] <= 4'h5;
          buf_q[12] <= seed[7:4];
          buf_q[13] <= seed[3:0];
          buf_q[14] <= seed[7:4];
          buf_q[15] <= seed[3:0];
          enc_base <= SEED_BASE;
          enc_left <= 3'(SEED_ROUNDS);
        end
      end else if (fall) begin
        armed <= 1'b1;
        if (!cur) line_pull <= 1'b1;
      end else if (rise && armed) begin
        armed <= 1'b0;
        line_pull <= 1'b0;
        if (!last) begin
          bitcnt <= bitcnt + 6'd1;
        end else begin
          bitcnt <= '0;
          case (phase)
            PH_ID:   phase <= PH_SEED;
            PH_SEED: begin
              phase <= PH_GAP;
              for (int i = 0; i < 4; i++) buf_q[i] <= '0;
              for (int j = 0; j < 12; j++) buf_q[4 + j] <= csum_q[(47 - 4 * j) -: 4];
              enc_base <= 4'd0;
              enc_left <= 3'(CSUM_ROUNDS);
            end
            PH_GAP:  phase <= PH_CSUM;
            default: begin
              phase <= PH_IDLE;
              done <= 1'b1;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/hs_frame_gen_chk.sv
module hs_frame_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fall,
  input logic       rise,
  input logic       line_pull,
  input logic       done,
  input logic [2:0] phase,
  input logic [5:0] bitcnt
);
  localparam logic [2:0] PH_IDLE = 3'd0, PH_ID = 3'd1, PH_GAP = 3'd3, PH_CSUM = 3'd4;

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_IDLE |-> !line_pull); // R1
  AST_PULL_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_pull) |-> $past(fall)); // R2
  AST_RELEASE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && line_pull && phase != PH_IDLE) |=> !line_pull); // R2
  AST_ID_TAIL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ID && bitcnt == 6'd3 && fall) |=> !line_pull); // R4
  AST_GAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_GAP && fall) |=> line_pull); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_FROM_CSUM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(phase) == PH_CSUM); // R9
endmodule

bind hs_frame_gen hs_frame_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .fall(fall), .rise(rise), .line_pull(line_pull),
  .done(done), .phase(phase), .bitcnt(bitcnt)
);

// File: tb/hs_frame_gen_test.sv
`timescale 1ns/1ps
module hs_frame_gen_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, region_pal = 1'b0, disk_mode = 1'b0, hs_clk = 1'b1;
  logic [7:0] seed = '0;
  logic [47:0] csum = '0;
  logic line_pull, done;
  int total = 0, bad = 0, cyc = 0;
  logic [92:0] got;
  int dsum, relbad;

  localparam int NV = 4;
  localparam logic [57:0] VEC [NV] = '{
    {8'h3F, 48'hA536C0F1D859, 1'b0, 1'b0},
    {8'h00, 48'h000000000000, 1'b1, 1'b1},
    {8'hFF, 48'hFFFFFFFFFFFF, 1'b0, 1'b1},
    {8'h5A, 48'h0123456789AB, 1'b1, 1'b0}
  };

  always #2 clk = ~clk;

  hs_frame_gen uut (.clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .csum(csum),
    .region_pal(region_pal), .disk_mode(disk_mode), .hs_clk(hs_clk),
    .line_pull(line_pull), .done(done));

  function automatic logic [63:0] enc_round(logic [63:0] b, int p);
    logic [3:0] dv = b[p*4 +: 4];
    for (int i = p + 1; i < 16; i++) begin
      dv = dv + 4'd1 + b[i*4 +: 4];
      b[i*4 +: 4] = dv;
    end
    return b;
  endfunction

  function automatic logic [92:0] expect_stream(logic [57:0] v);
    logic [92:0] s = '0;
    logic [63:0] b = '0;
    logic [7:0] sd = v[57:50];
    logic [47:0] cs = v[49:2];
    s[0] = v[0]; s[1] = v[1]; s[2] = 1'b0; s[3] = 1'b1;
    b[40 +: 4] = 4'hB; b[44 +: 4] = 4'h5;
    b[48 +: 4] = sd[7:4]; b[52 +: 4] = sd[3:0];
    b[56 +: 4] = sd[7:4]; b[60 +: 4] = sd[3:0];
    for (int r = 0; r < 2; r++) b = enc_round(b, 10);
    for (int n = 0; n < 6; n++)
      for (int k = 0; k < 4; k++) s[4 + n*4 + k] = b[(10 + n)*4 + 3 - k];
    s[28] = 1'b0;
    b = '0;
    for (int j = 0; j < 12; j++) b[(4 + j)*4 +: 4] = cs[(47 - 4*j) -: 4];
    for (int r = 0; r < 4; r++) b = enc_round(b, 0);
    for (int n = 0; n < 16; n++)
      for (int k = 0; k < 4; k++) s[29 + n*4 + k] = b[n*4 + 3 - k];
    return s;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [57:0] v);
    seed = v[57:50]; csum = v[49:2]; region_pal = v[1]; disk_mode = v[0];
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run_bits(int from, int to);
    for (int k = from; k <= to; k++) begin
      @(negedge clk) hs_clk = 1'b0;
      repeat (8) @(negedge clk);
      got[k] = ~line_pull;
      hs_clk = 1'b1;
      repeat (8) begin @(negedge clk); dsum += int'(done); end
      if (line_pull) relbad++;
    end
  endtask

  task automatic check_frame(logic [57:0] v, string tag);
    logic [92:0] e = expect_stream(v);
    check({tag, " R4 id"}, 128'(got[3:0]), 128'(e[3:0]));
    check({tag, " R3 R5 R6 seed"}, 128'(got[27:4]), 128'(e[27:4]));
    check({tag, " R8 gap"}, 128'(got[28]), 128'(e[28]));
    check({tag, " R3 R6 R7 checksum"}, 128'(got[92:29]), 128'(e[92:29]));
    check({tag, " R9 done count"}, 128'(dsum), 128'(1));
    check({tag, " R2 release"}, 128'(relbad), 128'(0));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset pull", 128'(line_pull), 128'(0));
    check("R1 reset done", 128'(done), 128'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v]); dsum = 0; relbad = 0;
      pulse_start();
      run_bits(0, 92);
      check_frame(VEC[v], $sformatf("vec%0d", v));
    end

    // R11: edges while idle
    dsum = 0; relbad = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) hs_clk = 1'b0;
      repeat (8) @(negedge clk);
      if (line_pull) relbad++;
      hs_clk = 1'b1;
      repeat (8) begin @(negedge clk); dsum += int'(done); end
    end
    check("R11 idle pull", 128'(relbad), 128'(0));
    check("R11 idle done", 128'(dsum), 128'(0));

    // R10: restart attempt mid-frame with altered inputs
    apply(VEC[0]); dsum = 0; relbad = 0;
    pulse_start();
    run_bits(0, 9);
    apply(VEC[3]);
    pulse_start();
    run_bits(10, 92);
    check_frame(VEC[0], "R10 busy");

    // R1: reset while the line is pulled low
    apply(VEC[1]); dsum = 0; relbad = 0;
    pulse_start();
    run_bits(0, 1);
    @(negedge clk) hs_clk = 1'b0;
    repeat (8) @(negedge clk);
    check("R2 pull on zero bit", 128'(line_pull), 128'(1));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 mid reset pull", 128'(line_pull), 128'(0));
    check("R1 mid reset done", 128'(done), 128'(0));
    rst_n = 1'b1;
    hs_clk = 1'b1;
    repeat (8) @(negedge clk);
    check("R1 idle after reset", 128'(line_pull), 128'(0));
    apply(VEC[3]); dsum = 0; relbad = 0;
    pulse_start();
    run_bits(0, 92);
    check_frame(VEC[3], "R1 post reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule